// File: doc/BRIEF.md
# Nine-Bit Oversampled Serial Receiver

This block receives asynchronous serial frames of eleven bit times. Each frame has a low start bit, eight data bits sent least significant first, a ninth bit and a high stop bit. The line is oversampled sixteen times per bit. Every bit, including the start bit, is settled by a two-of-three vote over the samples in the middle of the bit. The bit rate is the system clock divided by 64, or by 32 when the fast-rate select is high.

A finished frame is offered to the consumer through a held flag, `rx_full`, which acts as the valid signal. The consumer acknowledges by pulsing `flag_clr`. There is no ready signal and the receiver never stalls. Back-pressure works only by loss: a frame whose stop bit is reached while `rx_full` is still high is dropped, and the held byte is kept. In address mode, only frames whose ninth bit is 1 are offered. This lets a node on a shared line ignore data frames meant for other nodes.

The serial input passes through a two-flop synchronizer before its falling edges are detected. A falling edge seen while idle and enabled restarts the sample phase counter. This lines the sixteen-sample grid up with the incoming bit boundaries.

Top module: `nine_bit_rx`

## Requirements
- R1: After reset, `rx_full` is 0, `rx_byte` is 0x00 and `rx_bit9` is 0.
- R2: While `rx_en` is 0, falling edges on `rx_line` start no reception, and `rx_full`, `rx_byte` and `rx_bit9` keep their values.
- R3: One bit lasts 64 clock cycles when `rate_fast` is 0 and 32 clock cycles when it is 1. This is 16 samples per bit, taken every 4 or every 2 cycles.
- R4: A frame consists of a low start bit, then data bits 0 through 7 in that order, then the ninth bit, then the stop bit. The data bits go to `rx_byte[7:0]` and the ninth bit goes to `rx_bit9`.
- R5: Each bit takes the majority value of samples 7, 8 and 9 of its 16 samples (counted from 0 at the start edge). A single corrupted sample in any bit does not change the received value.
- R6: If the start-bit vote gives 1, reception is abandoned without any output change, and the receiver waits for a new falling edge.
- R7: The store decision is made at the middle of the stop bit. If `rx_full` is 1 at that moment, the frame is dropped and `rx_byte`, `rx_bit9` and `rx_full` are unchanged. The value of the stop bit is not checked.
- R8: When `addr_mode` is 1, a frame is stored only if its ninth bit is 1. When `addr_mode` is 0, a frame is stored whatever its ninth bit is.
- R9: On a store, `rx_byte` and `rx_bit9` take the frame's values and `rx_full` goes to 1. `rx_full` then stays at 1 until `flag_clr` is pulsed, and clearing it leaves `rx_byte` and `rx_bit9` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input line, idles high |
| rx_en | input | 1 | Receive enable; a start edge is accepted only when this is 1 |
| rate_fast | input | 1 | 0: bit time of 64 clocks; 1: bit time of 32 clocks |
| addr_mode | input | 1 | 1: store only frames whose ninth bit is 1 |
| flag_clr | input | 1 | One-cycle pulse that clears `rx_full` |
| rx_byte | output | DATA_W | Last stored data byte |
| rx_bit9 | output | 1 | Ninth bit of the last stored frame |
| rx_full | output | 1 | Frame-stored flag; acts as valid |

## Verification
The bench builds the receiver with its default parameters: eight data bits, sixteen samples per bit, and sample prescalers of 4 and 2. Both rates therefore give bit times of only 64 or 32 clocks. This short bit time lets the bench send many complete frames at both rates within a small cycle budget. A glitch as wide as one sample period always covers exactly one sample instant, so the single-sample corruption case for the vote can be produced reliably. A false start only a quarter of a bit long can also be produced at this scale.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/nbr_sync.sv
module nbr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign line_o = chain[STAGES-1];
  assign fall_o = prev & ~chain[STAGES-1];
endmodule

// File: rtl/nbr_ticker.sv
module nbr_ticker #(
  parameter int OVS      = 16,
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2,
  localparam int PW      = $clog2(SLOW_DIV),
  localparam int HW      = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast,
  input  logic          restart,
  output logic          tick_o,
  output logic [HW-1:0] phase_o
);
  logic [PW-1:0] pre;
  logic [PW-1:0] lim;

  assign lim    = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
  assign tick_o = (pre >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      phase_o <= '0;
    end else if (restart) begin
      pre     <= '0;
      phase_o <= '0;
    end else if (tick_o) begin
      pre     <= '0;
      phase_o <= (phase_o == HW'(OVS - 1)) ? '0 : phase_o + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/nbr_voter.sv
module nbr_voter #(
  parameter int OVS = 16,
  parameter int MID = 8,
  localparam int HW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [HW-1:0] phase,
  input  logic          line,
  output logic          vld_o,
  output logic          bit_o
);
  logic [1:0] early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early <= 2'b11;
      vld_o <= 1'b0;
      bit_o <= 1'b1;
    end else begin
      vld_o <= 1'b0;
      if (restart) begin
        early <= 2'b11;
      end else if (tick) begin
        if (phase == HW'(MID - 1)) early[0] <= line;
        if (phase == HW'(MID))     early[1] <= line;
        if (phase == HW'(MID + 1)) begin
          vld_o <= 1'b1;
          bit_o <= (early[0] & early[1]) | (early[0] & line) | (early[1] & line);
        end
      end
    end
  end
endmodule

// File: rtl/nine_bit_rx.sv
module nine_bit_rx import nbr_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SLOW_DIV    = 4,
  parameter int FAST_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic              rate_fast,
  input  logic              addr_mode,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              rx_full
);
  localparam int PH_W  = $clog2(OVS);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int MID   = OVS / 2;

  rx_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              nine_q;
  logic              line_s, fall, samp_tick, vote_vld, vote_bit;
  logic              restart, busy, in_start, store;
  logic [PH_W-1:0]   phase;

  nbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line), .line_o(line_s), .fall_o(fall)
  );

  nbr_ticker #(.OVS(OVS), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .fast(rate_fast), .restart(restart),
    .tick_o(samp_tick), .phase_o(phase)
  );

  nbr_voter #(.OVS(OVS), .MID(MID)) u_vote (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(samp_tick),
    .phase(phase), .line(line_s), .vld_o(vote_vld), .bit_o(vote_bit)
  );

  assign busy     = (state != ST_IDLE);
  assign in_start = (state == ST_START);
  assign restart  = fall & rx_en & ~busy;
  assign store    = vote_vld & (state == ST_STOP) & ~rx_full & (~addr_mode | nine_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      nine_q  <= 1'b0;
    end else if (restart) begin
      state <= ST_START;
    end else if (vote_vld) begin
      case (state)
        ST_START: begin
          state   <= vote_bit ? ST_IDLE : ST_DATA;
          bit_cnt <= '0;
        end
        ST_DATA: begin
          shreg <= {vote_bit, shreg[DATA_W-1:1]};
          if (bit_cnt == CNT_W'(DATA_W - 1)) state <= ST_NINTH;
          else bit_cnt <= bit_cnt + 1'b1;
        end
        ST_NINTH: begin
          nine_q <= vote_bit;
          state  <= ST_STOP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_byte <= '0;
      rx_bit9 <= 1'b0;
    end else if (store) begin
      rx_full <= 1'b1;
      rx_byte <= shreg;
      rx_bit9 <= nine_q;
    end else if (flag_clr) begin
      rx_full <= 1'b0;
    end
  end
endmodule

// File: rtl/nbr_checker.sv
module nbr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              addr_mode,
  input logic              flag_clr,
  input logic              rx_full,
  input logic              rx_bit9,
  input logic [DATA_W-1:0] rx_byte,
  input logic              busy,
  input logic              in_start,
  input logic              samp_tick,
  input logic              vote_vld,
  input logic              vote_bit
);
  AST_FULL_FREEZES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> ($stable(rx_byte) && $stable(rx_bit9))); // R7
  AST_FULL_HELD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !flag_clr) |=> rx_full); // R9
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !busy) |=> !busy); // R2
  AST_ADDR_NEEDS_BIT9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && $past(addr_mode)) |-> rx_bit9); // R8
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |=> !samp_tick); // R3
  AST_FALSE_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_start && vote_vld && vote_bit) |=> !busy); // R6
endmodule

bind nine_bit_rx nbr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .addr_mode(addr_mode),
  .flag_clr(flag_clr), .rx_full(rx_full), .rx_bit9(rx_bit9), .rx_byte(rx_byte),
  .busy(busy), .in_start(in_start), .samp_tick(samp_tick),
  .vote_vld(vote_vld), .vote_bit(vote_bit)
);

// File: tb/tb_nine_bit_rx.sv
`timescale 1ns/1ps
module tb_nine_bit_rx;
  localparam int SLOW_BIT = 64;
  localparam int FAST_BIT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic rx_en = 1'b0;
  logic rate_fast = 1'b0;
  logic addr_mode = 1'b0;
  logic flag_clr = 1'b0;
  logic [7:0] rx_byte;
  logic rx_bit9, rx_full;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_byte = 8'h00;
  logic exp_bit9 = 1'b0;
  logic exp_full = 1'b0;

  always #2.5 clk = ~clk;

  nine_bit_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_en(rx_en),
    .rate_fast(rate_fast), .addr_mode(addr_mode), .flag_clr(flag_clr),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_full(rx_full)
  );

  // fields: fast, addr_mode, glitch, expect_store, bit9, data[7:0]
  localparam logic [12:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC3},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0F},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hF0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "rx_byte", {1'b0, rx_byte}, {1'b0, exp_byte});
    chk(req, "rx_bit9", {8'b0, rx_bit9}, {8'b0, exp_bit9});
    chk(req, "rx_full", {8'b0, rx_full}, {8'b0, exp_full});
  endtask

  task automatic hold_line(input logic v, input int clocks);
    rx_line = v;
    repeat (clocks) @(negedge clk);
  endtask

  // glitch inverts the line for one sample period around the bit middle
  task automatic send_bit(input logic v, input int blen, input logic glitch);
    if (glitch) begin
      hold_line(v, blen / 2);
      hold_line(~v, blen / 16);
      hold_line(v, blen - blen / 2 - blen / 16);
    end else begin
      hold_line(v, blen);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic fast, input logic glitch);
    int blen;
    blen = fast ? FAST_BIT : SLOW_BIT;
    send_bit(1'b0, blen, glitch);
    for (int k = 0; k < 8; k++) send_bit(d[k], blen, glitch);
    send_bit(b9, blen, glitch);
    send_bit(1'b1, blen, glitch);
    hold_line(1'b1, 2 * blen);
  endtask

  task automatic pulse_clear();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_full = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");
    rx_en = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [12:0] v;
      v = VECS[i];
      pulse_clear();
      rate_fast = v[12];
      addr_mode = v[11];
      send_frame(v[7:0], v[8], v[12], v[10]);
      if (v[9]) begin
        exp_byte = v[7:0];
        exp_bit9 = v[8];
        exp_full = 1'b1;
      end
      if (v[10])      chk_all("R5");
      else if (v[11]) chk_all("R8");
      else if (v[12]) chk_all("R3");
      else            chk_all("R4");
    end

    // R7: flag still set from the last vector, new frame must be dropped
    addr_mode = 1'b0;
    rate_fast = 1'b0;
    send_frame(8'h12, 1'b0, 1'b0, 1'b0);
    chk_all("R7");

    // R9: clearing drops the flag and keeps the data
    pulse_clear();
    @(negedge clk);
    chk_all("R9");

    // R2: disabled receiver ignores a full frame
    rx_en = 1'b0;
    send_frame(8'h99, 1'b1, 1'b0, 1'b0);
    chk_all("R2");
    rx_en = 1'b1;

    // R6: quarter-bit low pulse is rejected, then a real frame is received
    hold_line(1'b0, SLOW_BIT / 4);
    hold_line(1'b1, 3 * SLOW_BIT);
    chk_all("R6");
    send_frame(8'h6B, 1'b0, 1'b0, 1'b0);
    exp_byte = 8'h6B;
    exp_bit9 = 1'b0;
    exp_full = 1'b1;
    chk_all("R6");

    // R4: fast frame with a single set bit after clearing
    pulse_clear();
    rate_fast = 1'b1;
    send_frame(8'h01, 1'b1, 1'b1, 1'b0);
    exp_byte = 8'h01;
    exp_bit9 = 1'b1;
    exp_full = 1'b1;
    chk_all("R4");

    summary();
    $finish;
  end
endmodule